// File: doc/BRIEF.md
# CAN Receive Message Store

This block holds received CAN frames between the protocol engine and the host register bus. The engine delivers each frame as a stream of bytes. The first byte is the frame-info byte, the identifier bytes follow, and the data bytes come last. Frames are packed back to back into a circular byte store. The host sees the oldest pending frame through a fixed byte window and frees it with a release command. A message counter, a pending status bit, a sticky overrun status bit and two interrupt flags report the store's state.

The engine interface uses valid/ready. `rx_ready` is held high at all times, so the store never applies back-pressure, because the bus cannot be stalled. When the info byte arrives, the block computes the frame's stored length. If the free space is smaller than that length, the whole frame is discarded, every one of its beats is still accepted, and an overrun is recorded. `rx_last` closes a frame. The register bus is a simple single-cycle write strobe with a combinational read. Reads have no side effects.

Top module: `can_rx_msgbuf`

## Requirements
- R1: After reset the count register (0x10), status (0x04), interrupt flags (0x08) and every window word read 0, `irq` is low and `rx_ready` is high.
- R2: Window word k sits at byte address 0x40+4k and carries byte k of the head frame in bits 7:0. Byte 0 is the info byte: bit 7 marks an extended frame, bit 6 marks a remote frame, and bits 3:0 hold the DLC. A standard frame keeps identifier bytes at k=1..2 and data from k=3.
- R3: An extended frame keeps identifier bytes at k=1..4 and data from k=5.
- R4: The stored length is the header (3 bytes standard, 5 bytes extended) plus min(DLC,8) data bytes, and a remote frame has no data bytes. Beats past that length are discarded, and window words at or past the length read 0.
- R5: Frames are presented oldest first. Writing command register 0x00 with bit 2 set retires the head frame, decrements the count and shows the next frame.
- R6: A release while the count is 0 is ignored. The count stays 0 and the next frame is stored and shown normally.
- R7: Status bit 0 reads 1 exactly while the count is nonzero, and the window reads 0 while the count is 0.
- R8: A frame whose stored length exceeds the free bytes is dropped whole, and frames already stored are unchanged. A drop sets status bit 1, which stays set until a command write with bit 3 set.
- R9: Interrupt flag bit 0 sets when a frame is stored and flag bit 3 sets when a frame is dropped. Each flag sets only while its enable bit (same position at 0x0C) is 1. Writing 1 to a flag bit at 0x08 clears it. `irq` is the OR of the flags that are set and enabled.
- R10: `rx_ready` stays high while beats are offered, including beats of a dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Engine byte valid |
| rx_ready | output | 1 | Store accepts a byte (always high) |
| rx_byte | input | 8 | Frame byte from the engine |
| rx_last | input | 1 | Final byte of the frame |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A head pointer that is out of step shows up at the next window read as a misaligned info byte. A wrong length computation shows up one release later as garbage in the following frame. Errors in free-space accounting show up as a drop or a stored frame on the wrong arrival, visible in the count and the overrun bit on the next read. Flag or enable gating faults show on `irq` in the cycle after the store or drop event. The bench follows every operation with a full sweep of the count, the status, the flags and all thirteen window words.

// File: rtl/can_rxb_pkg.sv
package can_rxb_pkg;
  localparam int WIN_BYTES = 13;

  localparam logic [7:0] ADR_CMD   = 8'h00;
  localparam logic [7:0] ADR_STAT  = 8'h04;
  localparam logic [7:0] ADR_IFLAG = 8'h08;
  localparam logic [7:0] ADR_IEN   = 8'h0C;
  localparam logic [7:0] ADR_COUNT = 8'h10;

  localparam int CMD_RELEASE = 2;
  localparam int CMD_CLR_OVR = 3;
  localparam int IRQ_RX      = 0;
  localparam int IRQ_OVR     = 3;

  // Stored length of a frame from its info byte: header plus clamped data.
  function automatic logic [3:0] frame_len(input logic [7:0] info);
    logic [3:0] dbytes;
    dbytes = info[6] ? 4'd0 : ((info[3:0] > 4'd8) ? 4'd8 : info[3:0]);
    return (info[7] ? 4'd5 : 4'd3) + dbytes;
  endfunction
endpackage

// File: rtl/can_rxb_ingest.sv
module can_rxb_ingest
  import can_rxb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [7:0]                   in_data,
  input  logic                         in_last,
  input  logic [$clog2(DEPTH):0]       free_bytes,
  input  logic [$clog2(DEPTH)-1:0]     wr_base,
  output logic                         wr_en,
  output logic [$clog2(DEPTH)-1:0]     wr_addr,
  output logic [7:0]                   wr_byte,
  output logic                         commit,
  output logic [3:0]                   commit_len,
  output logic                         drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = PW + 1;

  logic       active_q, keep_q;
  logic [3:0] idx_q, len_q;
  logic       first;
  logic [3:0] len_now, idx_now;
  logic       keep_now;
  logic [FW-1:0] sum;

  always_comb begin
    first    = !active_q;
    len_now  = first ? frame_len(in_data) : len_q;
    idx_now  = first ? 4'd0 : idx_q;
    keep_now = first ? (free_bytes >= FW'(len_now)) : keep_q;
    sum      = {1'b0, wr_base} + FW'(idx_now);
    if (int'(sum) >= DEPTH) sum = sum - FW'(DEPTH);
  end

  assign wr_en      = in_valid && keep_now && (idx_now < len_now);
  assign wr_addr    = sum[PW-1:0];
  assign wr_byte    = in_data;
  assign commit     = in_valid && in_last && keep_now;
  assign commit_len = len_now;
  assign drop       = in_valid && first && !keep_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
      idx_q    <= 4'd0;
      len_q    <= 4'd0;
    end else if (in_valid) begin
      active_q <= !in_last;
      keep_q   <= keep_now;
      len_q    <= len_now;
      idx_q    <= (idx_now == 4'd15) ? 4'd15 : idx_now + 4'd1;
    end
  end

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !wr_en); // R8
  AST_COMMIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && first) |-> (free_bytes >= FW'(commit_len))); // R8
endmodule

// File: rtl/can_rxb_store.sv
module can_rxb_store
  import can_rxb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(DEPTH)-1:0]             wr_addr,
  input  logic [7:0]                           wr_byte,
  input  logic                                 commit,
  input  logic [3:0]                           commit_len,
  input  logic                                 rel_req,
  input  logic [3:0]                           win_idx,
  output logic [7:0]                           win_byte,
  output logic [$clog2(DEPTH):0]               free_bytes,
  output logic [$clog2(DEPTH)-1:0]             wr_ptr,
  output logic [$clog2(DEPTH/3+1)-1:0]         count,
  output logic                                 pending
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = PW + 1;
  localparam int CW = $clog2(DEPTH/3+1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [FW-1:0] used_q;
  logic [CW-1:0] count_q;
  logic [3:0]    head_len;
  logic [PW-1:0] rd_addr;
  logic          do_rel;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] b, input logic [3:0] o);
    logic [FW-1:0] s;
    s = {1'b0, b} + FW'(o);
    if (int'(s) >= DEPTH) s = s - FW'(DEPTH);
    return s[PW-1:0];
  endfunction

  assign pending    = (count_q != '0);
  assign head_len   = frame_len(mem[rd_ptr_q]);
  assign rd_addr    = wrap_add(rd_ptr_q, win_idx);
  assign win_byte   = (pending && (win_idx < head_len)) ? mem[rd_addr] : 8'h00;
  assign do_rel     = rel_req && pending;
  assign free_bytes = FW'(DEPTH) - used_q;
  assign wr_ptr     = wr_ptr_q;
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      used_q   <= '0;
      count_q  <= '0;
    end else begin
      if (commit) wr_ptr_q <= wrap_add(wr_ptr_q, commit_len);
      if (do_rel) rd_ptr_q <= wrap_add(rd_ptr_q, head_len);
      used_q  <= used_q + (commit ? FW'(commit_len) : '0) - (do_rel ? FW'(head_len) : '0);
      count_q <= count_q + CW'(commit) - CW'(do_rel);
    end
  end

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_q) <= DEPTH); // R8
  AST_EMPTY_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) == (used_q == '0)); // R5
  AST_REL_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !pending && !commit) |=> (count_q == '0) && $stable(rd_ptr_q)); // R6
endmodule

// File: rtl/can_rxb_regs.sv
module can_rxb_regs
  import can_rxb_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [CW-1:0] count,
  input  logic          pending,
  input  logic [7:0]    win_byte,
  output logic [3:0]    win_idx,
  input  logic          ev_rx,
  input  logic          ev_ovr,
  output logic          rel_req,
  output logic          irq
);
  logic ovr_q, f_rx_q, f_ovr_q, en_rx_q, en_ovr_q;
  logic cmd_wr, flag_wr, en_wr, clr_ovr, win_hit;
  logic unused_bits;

  assign cmd_wr  = bus_we && (bus_addr[7:2] == ADR_CMD[7:2]);
  assign flag_wr = bus_we && (bus_addr[7:2] == ADR_IFLAG[7:2]);
  assign en_wr   = bus_we && (bus_addr[7:2] == ADR_IEN[7:2]);
  assign rel_req = cmd_wr && bus_wdata[CMD_RELEASE];
  assign clr_ovr = cmd_wr && bus_wdata[CMD_CLR_OVR];
  assign win_idx = bus_addr[5:2];
  assign win_hit = (bus_addr[7:6] == 2'b01) && (int'(bus_addr[5:2]) < WIN_BYTES);
  assign irq     = (f_rx_q && en_rx_q) || (f_ovr_q && en_ovr_q);
  assign unused_bits = ^{bus_wdata[31:4], bus_wdata[1], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q    <= 1'b0;
      f_rx_q   <= 1'b0;
      f_ovr_q  <= 1'b0;
      en_rx_q  <= 1'b0;
      en_ovr_q <= 1'b0;
    end else begin
      if (ev_ovr)       ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;

      if (ev_rx && en_rx_q)                      f_rx_q <= 1'b1;
      else if (flag_wr && bus_wdata[IRQ_RX])     f_rx_q <= 1'b0;

      if (ev_ovr && en_ovr_q)                    f_ovr_q <= 1'b1;
      else if (flag_wr && bus_wdata[IRQ_OVR])    f_ovr_q <= 1'b0;

      if (en_wr) begin
        en_rx_q  <= bus_wdata[IRQ_RX];
        en_ovr_q <= bus_wdata[IRQ_OVR];
      end
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (win_hit) bus_rdata = {24'h0, win_byte};
    else begin
      unique case (bus_addr[7:2])
        ADR_STAT[7:2]:  bus_rdata = {30'h0, ovr_q, pending};
        ADR_IFLAG[7:2]: bus_rdata = {28'h0, f_ovr_q, 2'b00, f_rx_q};
        ADR_IEN[7:2]:   bus_rdata = {28'h0, en_ovr_q, 2'b00, en_rx_q};
        ADR_COUNT[7:2]: bus_rdata = {{(32-CW){1'b0}}, count};
        default:        bus_rdata = 32'h0;
      endcase
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q); // R8
  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && en_rx_q) |=> f_rx_q); // R9
  AST_RX_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_rx_q && !(ev_rx && en_rx_q)) |=> !f_rx_q); // R9
endmodule

// File: rtl/can_rx_msgbuf.sv
module can_rx_msgbuf
  import can_rxb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH/3+1);

  logic          wr_en, commit, drop, rel_req, pending;
  logic [PW-1:0] wr_addr, wr_ptr;
  logic [7:0]    wr_byte, win_byte;
  logic [3:0]    commit_len, win_idx;
  logic [PW:0]   free_bytes;
  logic [CW-1:0] count;

  assign rx_ready = 1'b1;

  can_rxb_ingest #(.DEPTH(DEPTH)) u_ingest (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_byte), .in_last(rx_last),
    .free_bytes(free_bytes), .wr_base(wr_ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .commit(commit), .commit_len(commit_len), .drop(drop)
  );

  can_rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .commit(commit), .commit_len(commit_len), .rel_req(rel_req),
    .win_idx(win_idx), .win_byte(win_byte),
    .free_bytes(free_bytes), .wr_ptr(wr_ptr),
    .count(count), .pending(pending)
  );

  can_rxb_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .pending(pending), .win_byte(win_byte), .win_idx(win_idx),
    .ev_rx(commit), .ev_ovr(drop), .rel_req(rel_req), .irq(irq)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_ready); // R10
endmodule

// File: tb/can_rx_msgbuf_bench.sv
module can_rx_msgbuf_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_byte = 8'h0;
  logic        rx_ready;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec = 0, n_bad = 0;

  logic [103:0] mq[$];
  int  model_used = 0;
  bit  m_ovr = 0, mf_rx = 0, mf_ovr = 0, men_rx = 0, men_ovr = 0;

  always #5 clk = ~clk;

  can_rx_msgbuf #(.DEPTH(DEPTH)) u_can_rx_msgbuf (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .rx_last(rx_last), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int exp_data(input logic [7:0] info);
    int d;
    d = int'(info[3:0]);
    if (d > 8) d = 8;
    return d;
  endfunction

  function automatic int exp_len(input logic [7:0] info);
    return (info[7] ? 5 : 3) + (info[6] ? 0 : exp_data(info));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [103:0] fr;
    int ln;
    rd(8'h10, d); chk({tag, " R5 count"}, d, 32'(mq.size()));
    rd(8'h04, d); chk({tag, " R7 R8 status"}, d, {30'h0, m_ovr, (mq.size() != 0)});
    rd(8'h08, d); chk({tag, " R9 flags"}, d, {28'h0, mf_ovr, 2'b00, mf_rx});
    chk({tag, " R9 irq"}, 32'(irq), 32'((mf_rx & men_rx) | (mf_ovr & men_ovr)));
    fr = (mq.size() != 0) ? mq[0] : '0;
    ln = (mq.size() != 0) ? exp_len(fr[7:0]) : 0;
    for (int k = 0; k < 13; k++) begin
      rd(8'(8'h40 + 4*k), d);
      chk({tag, " R2 R3 R4 window"}, d, (k < ln) ? {24'h0, fr[8*k +: 8]} : 32'h0);
    end
  endtask

  task automatic send_frame(input bit ext, input bit rtr, input logic [3:0] dlc, input int extra);
    logic [7:0] b [16];
    logic [103:0] fr;
    int ln, nsend;
    b[0] = {ext, rtr, 2'b00, dlc};
    for (int i = 1; i < 16; i++) b[i] = 8'($urandom);
    ln = exp_len(b[0]);
    nsend = (ext ? 5 : 3) + exp_data(b[0]) + extra;
    if (nsend > 16) nsend = 16;
    fr = '0;
    for (int i = 0; i < 13; i++) if (i < ln) fr[8*i +: 8] = b[i];
    for (int i = 0; i < nsend; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b[i]; rx_last = (i == nsend - 1);
      chk("R10 ready", 32'(rx_ready), 32'd1);
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0;
    end
    if (DEPTH - model_used >= ln) begin
      mq.push_back(fr);
      model_used += ln;
      if (men_rx) mf_rx = 1;
    end else begin
      m_ovr = 1;
      if (men_ovr) mf_ovr = 1;
    end
  endtask

  task automatic release_head();
    logic [103:0] fr;
    wr(8'h00, 32'h4);
    if (mq.size() != 0) begin
      fr = mq.pop_front();
      model_used -= exp_len(fr[7:0]);
    end
  endtask

  task automatic set_en(input bit rx_en, input bit ovr_en);
    wr(8'h0C, {28'h0, ovr_en, 2'b00, rx_en});
    men_rx = rx_en; men_ovr = ovr_en;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check_all("R1 reset");
    chk("R1 ready", 32'(rx_ready), 32'd1);

    // R2 standard frame, R3 extended frame
    set_en(1, 1);
    send_frame(0, 0, 4'd2, 0);
    check_all("R2 std");
    send_frame(1, 0, 4'd8, 0);
    release_head();
    check_all("R3 ext");
    wr(8'h08, 32'h9); mf_rx = 0; mf_ovr = 0;
    check_all("R9 w1c");

    // R4: remote frame with extra beats, DLC above 8
    send_frame(0, 1, 4'd5, 5);
    send_frame(1, 0, 4'd12, 2);
    release_head();
    check_all("R4 remote");
    release_head();
    check_all("R4 clamp");

    // R6: release on empty store
    release_head();
    check_all("R6 empty");
    release_head();
    send_frame(0, 0, 4'd1, 0);
    check_all("R6 after");
    release_head();

    // R8: fill with 13-byte frames until one is dropped
    for (int i = 0; i < 5; i++) send_frame(1, 0, 4'd8, 0);
    check_all("R8 full");
    send_frame(0, 0, 4'd8, 0);
    check_all("R8 fits");
    release_head();
    check_all("R8 sticky");
    wr(8'h00, 32'h8); m_ovr = 0;
    check_all("R8 clear");

    // R9: disabled enables gate the flags
    wr(8'h08, 32'h9); mf_rx = 0; mf_ovr = 0;
    set_en(0, 0);
    send_frame(0, 0, 4'd3, 0);
    check_all("R9 gated");
    while (mq.size() != 0) release_head();

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5) send_frame(1'($urandom), 1'($urandom), 4'($urandom), int'($urandom % 3));
      else if (r < 8) release_head();
      else if (r == 8) begin wr(8'h00, 32'h8); m_ovr = 0; end
      else begin
        wr(8'h08, 32'h9); mf_rx = 0; mf_ovr = 0;
        set_en(1'($urandom), 1'($urandom));
      end
      check_all("rand R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule